// File: doc/BRIEF.md
# Cascadable Up/Down Presettable Counter

A synchronous binary counter built from identical 4-bit stages. Each stage counts modulo 16. It counts up or down depending on a direction input, and it can be preset from a parallel data input. Every state change happens on the rising clock edge. The stages are chained through an active-low trickle enable and an active-low terminal-count output, so the chain behaves as one wide synchronous counter with no extra gating.

A stage advances only when the shared active-low count enable and its own active-low trickle enable are both low. The first stage takes its trickle enable from the top-level chain enable. Each later stage takes its trickle enable from the terminal-count output of the stage before it. An active-low load has priority over both enables. A synchronous active-high reset has priority over everything and clears the count.

The terminal count of a stage is decoded combinationally from three things: its count, the direction and its trickle enable. It never depends on the count enable or the load input, so the trickle chain can ripple through many stages. The terminal count of the last stage is the terminal count of the whole chain.

Top module: `updn_chain`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes zero at that edge, whatever the other inputs are.
- R2: When `rst` is low and `ld_n` is low at a rising edge, `q` takes the value of `din` at that edge, whatever the levels of `dir_up`, `cnt_en_n` and `chain_en_n`.
- R3: With `rst` high-inactive (low), `ld_n` high, `cnt_en_n` low, `chain_en_n` low and `dir_up` high (1 = up), `q` increases by one at each rising edge, including carries between 4-bit stages.
- R4: Under the same conditions with `dir_up` low (0 = down), `q` decreases by one at each rising edge, including borrows between 4-bit stages.
- R5: With `ld_n` high, `q` holds its value across a rising edge whenever `cnt_en_n` or `chain_en_n` is high.
- R6: The full count wraps. Counting up from all ones gives zero, and counting down from zero gives all ones. Each 4-bit stage likewise wraps through its 16 states.
- R7: `tc_n` is low exactly when `chain_en_n` is low and the count is at its terminal value: all ones when `dir_up` is 1, zero when `dir_up` is 0. This decode is combinational and ignores `cnt_en_n` and `ld_n`.
- R8: While `chain_en_n` is high, `tc_n` is high.
- R9: A change of `dir_up` in the middle of a count takes effect at the very next rising edge. No extra step is taken and no step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| ld_n | input | 1 | Active-low synchronous preset from `din` |
| dir_up | input | 1 | Count direction: 1 up, 0 down |
| cnt_en_n | input | 1 | Active-low count enable shared by all stages |
| chain_en_n | input | 1 | Active-low trickle enable into the first stage |
| din | input | STAGE_W*STAGES | Preset value |
| q | output | STAGE_W*STAGES | Current count |
| tc_n | output | 1 | Active-low terminal count of the last stage |

## Verification
The bench drives the count across the 0x0FF/0x100 carry boundary and the 0x100/0x0FF borrow boundary. A stage that wrongly takes its trickle enable from the shared enable would step its upper nibbles on every clock and fail there. Loads are applied with the enables both high and both low, which exposes any load that a disabled enable can block. A full wrap through all 4096 states in each direction, together with reversals in the middle of a count, catches an off-by-one direction decode. The terminal count is checked with load active and the count enable high, which exposes a decode that wrongly includes those inputs.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } stage_op_e;
endpackage

// File: rtl/cnt_op_select.sv
module cnt_op_select
  import updn_pkg::*;
(
  input  logic      ld_n,
  input  logic      dir_up,
  input  logic      cnt_en_n,
  input  logic      trk_en_n,
  output stage_op_e op
);
  // load wins over both enables; counting needs both enables low
  always_comb begin
    if (!ld_n)                      op = OP_LOAD;
    else if (!cnt_en_n && !trk_en_n) op = dir_up ? OP_INC : OP_DEC;
    else                            op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  stage_op_e    op,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_INC:  nxt = cur + ONE;
      OP_DEC:  nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_tc_decode.sv
module cnt_tc_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir_up,
  input  logic         trk_en_n,
  output logic         tc_n
);
  logic at_top;
  logic at_bot;

  assign at_top = &cur;
  assign at_bot = ~|cur;
  assign tc_n   = ~(~trk_en_n & (dir_up ? at_top : at_bot));
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic         dir_up,
  input  logic         cnt_en_n,
  input  logic         trk_en_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc_n
);
  stage_op_e   op;
  logic [W-1:0] nxt;

  cnt_op_select u_sel (
    .ld_n     (ld_n),
    .dir_up   (dir_up),
    .cnt_en_n (cnt_en_n),
    .trk_en_n (trk_en_n),
    .op       (op)
  );

  cnt_next_state #(.W(W)) u_nxt (
    .cur (q),
    .din (din),
    .op  (op),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  cnt_tc_decode #(.W(W)) u_tc (
    .cur      (q),
    .dir_up   (dir_up),
    .trk_en_n (trk_en_n),
    .tc_n     (tc_n)
  );
endmodule

// File: rtl/updn_chain.sv
module updn_chain #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 3,
  localparam int CW     = STAGE_W * STAGES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_n,
  input  logic          dir_up,
  input  logic          cnt_en_n,
  input  logic          chain_en_n,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] q,
  output logic          tc_n
);
  // link[i] is the trickle enable of stage i; link[STAGES] is the chain output
  logic [STAGES:0] link;

  assign link[0] = chain_en_n;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .ld_n     (ld_n),
      .dir_up   (dir_up),
      .cnt_en_n (cnt_en_n),
      .trk_en_n (link[i]),
      .din      (din[i*STAGE_W +: STAGE_W]),
      .q        (q[i*STAGE_W +: STAGE_W]),
      .tc_n     (link[i+1])
    );
  end

  assign tc_n = link[STAGES];
endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 3,
  localparam int CW     = STAGE_W * STAGES
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_n,
  input logic          dir_up,
  input logic          cnt_en_n,
  input logic          chain_en_n,
  input logic [CW-1:0] din,
  input logic [CW-1:0] q,
  input logic          tc_n
);
  localparam logic [CW-1:0] ONE = CW'(1);

  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> q == $past(din)); // R2

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !cnt_en_n && !chain_en_n && dir_up) |=> q == CW'($past(q) + ONE)); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !cnt_en_n && !chain_en_n && !dir_up) |=> q == CW'($past(q) - ONE)); // R4

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (ld_n && (cnt_en_n || chain_en_n)) |=> $stable(q)); // R5

  AST_TC_TOP_UP: assert property (@(posedge clk) disable iff (rst)
    (!chain_en_n && dir_up && (&q)) |-> !tc_n); // R7

  AST_TC_BOTTOM_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!chain_en_n && !dir_up && q == '0) |-> !tc_n); // R7

  AST_TC_GATED: assert property (@(posedge clk) disable iff (rst)
    chain_en_n |-> tc_n); // R8
endmodule

bind updn_chain updn_chain_chk #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ld_n       (ld_n),
  .dir_up     (dir_up),
  .cnt_en_n   (cnt_en_n),
  .chain_en_n (chain_en_n),
  .din        (din),
  .q          (q),
  .tc_n       (tc_n)
);

// File: tb/updn_chain_tb.sv
module updn_chain_tb;
  localparam int CLK_P   = 10;
  localparam int STAGE_W = 4;
  localparam int STAGES  = 3;
  localparam int CW      = STAGE_W * STAGES;
  localparam logic [CW-1:0] ALL1 = '1;

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_n;
  logic          dir_up;
  logic          cnt_en_n;
  logic          chain_en_n;
  logic [CW-1:0] din;
  logic [CW-1:0] q;
  logic          tc_n;

  logic [CW-1:0] mq;
  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  updn_chain #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst(rst), .ld_n(ld_n), .dir_up(dir_up),
    .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n),
    .din(din), .q(q), .tc_n(tc_n)
  );

  function automatic logic exp_tc();
    return !(!chain_en_n && (dir_up ? (mq == ALL1) : (mq == '0)));
  endfunction

  task automatic chk_q(input string tag);
    tests++;
    if (q !== mq) begin
      fails++;
      $display("FAIL %s: q got %h expected %h", tag, q, mq);
    end
  endtask

  task automatic chk_tc(input string tag);
    logic e;
    e = exp_tc();
    tests++;
    if (tc_n !== e) begin
      fails++;
      $display("FAIL %s: tc_n got %b expected %b", tag, tc_n, e);
    end
  endtask

  // set inputs at the falling edge, update the model, cross one rising edge
  task automatic apply(input logic l, input logic u, input logic ce,
                       input logic ch, input logic [CW-1:0] d);
    ld_n = l; dir_up = u; cnt_en_n = ce; chain_en_n = ch; din = d;
    #1;
    if (rst)            mq = '0;
    else if (!l)        mq = d;
    else if (!ce && !ch) mq = u ? mq + CW'(1) : mq - CW'(1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_q("R1 reset state");
    dir_up = 1'b1; chain_en_n = 1'b0; #1;
    chk_tc("R7 up at zero not terminal");
    dir_up = 1'b0; #1;
    chk_tc("R7 down at zero terminal");
  endtask

  task automatic t_load();
    apply(1'b0, 1'b1, 1'b1, 1'b1, 12'hABC);
    chk_q("R2 load with enables high");
    apply(1'b0, 1'b0, 1'b0, 1'b0, 12'h3D5);
    chk_q("R2 load over active count");
  endtask

  task automatic t_carry();
    apply(1'b0, 1'b1, 1'b1, 1'b1, 12'h0FE);
    for (int i = 0; i < 3; i++) begin
      apply(1'b1, 1'b1, 1'b0, 1'b0, '0);
      chk_q("R3 up across carry");
      chk_tc("R7 up mid count");
    end
  endtask

  task automatic t_borrow();
    apply(1'b0, 1'b0, 1'b1, 1'b1, 12'h101);
    for (int i = 0; i < 3; i++) begin
      apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
      chk_q("R4 down across borrow");
    end
  endtask

  task automatic t_wrap();
    apply(1'b0, 1'b1, 1'b1, 1'b1, ALL1);
    chain_en_n = 1'b0; #1;
    chk_tc("R7 terminal at all ones up");
    apply(1'b1, 1'b1, 1'b0, 1'b0, '0);
    chk_q("R6 up wrap to zero");
    apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk_q("R6 down wrap to all ones");
    for (int i = 0; i < 4096; i++) apply(1'b1, 1'b1, 1'b0, 1'b0, '0);
    chk_q("R6 full cycle up returns");
    for (int i = 0; i < 4096; i++) apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk_q("R6 full cycle down returns");
  endtask

  task automatic t_hold();
    apply(1'b0, 1'b1, 1'b1, 1'b1, 12'h0FF);
    apply(1'b1, 1'b1, 1'b1, 1'b0, '0);
    chk_q("R5 hold count enable high");
    apply(1'b1, 1'b1, 1'b0, 1'b1, '0);
    chk_q("R5 hold chain enable high");
    apply(1'b0, 1'b1, 1'b1, 1'b1, ALL1);
    ld_n = 1'b1; dir_up = 1'b1; chain_en_n = 1'b1; #1;
    chk_tc("R8 chain enable high gates tc");
  endtask

  task automatic t_tc_indep();
    apply(1'b0, 1'b1, 1'b1, 1'b1, ALL1);
    ld_n = 1'b0; cnt_en_n = 1'b1; chain_en_n = 1'b0; dir_up = 1'b1; din = 12'h123; #1;
    chk_tc("R7 tc ignores load and count enable");
    apply(1'b1, 1'b0, 1'b1, 1'b0, '0);
    chk_tc("R7 all ones down not terminal");
  endtask

  task automatic t_dir_change();
    apply(1'b0, 1'b1, 1'b1, 1'b1, 12'h7F8);
    apply(1'b1, 1'b1, 1'b0, 1'b0, '0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, '0);
    chk_q("R9 up before reversal");
    apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk_q("R9 first step after reversal");
    apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
    apply(1'b1, 1'b0, 1'b0, 1'b0, '0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, '0);
    chk_q("R9 second reversal");
  endtask

  task automatic t_reset_mid();
    apply(1'b0, 1'b1, 1'b1, 1'b1, 12'h456);
    rst = 1'b1;
    apply(1'b0, 1'b1, 1'b0, 1'b0, 12'h555);
    rst = 1'b0;
    chk_q("R1 reset beats load");
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_n = 1'b1; dir_up = 1'b1; cnt_en_n = 1'b1; chain_en_n = 1'b1; din = '0;
    mq = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_carry();
    t_borrow();
    t_wrap();
    t_hold();
    t_tc_indep();
    t_dir_change();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule